// File: doc/BRIEF.md
# Non-Restoring Sequential Divider

This block divides one unsigned integer by another over several clock cycles and produces one quotient bit per cycle. A wide residual register, a dividend/quotient shift register and a held divisor register make up the datapath. Every cycle shifts the residual and the quotient register left together as one unit, then adds or subtracts the divisor. The choice depends only on the sign the residual had before that step. The new quotient bit is the inverse of the sign that results. A negative residual is never restored during the iterations. When the last iteration leaves the residual negative, one extra cycle adds the divisor back to form the remainder.

A caller raises `start` for one cycle with the operands present. `busy` covers the computation, and `done` pulses for one cycle when `quotient` and `remainder` are valid. Both outputs then hold until the next operation completes. A zero divisor is caught when `start` is sampled. The block then finishes at once with a flag raised, an all-ones quotient and the dividend returned as remainder.

Top module: `nrdiv_top`

## Requirements
- R1: After reset, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: For a non-zero divisor, `quotient` equals the integer part of dividend/divisor and `remainder` equals dividend minus quotient times divisor (for example 27 divided by 5 gives 5 remainder 2).
- R3: With a non-zero divisor, `done` is high W clock edges after the edge that samples `start` when the quotient's least significant bit is 1. It is high W+1 edges after that edge when the bit is 0, which is when the one remainder-correction cycle is used.
- R4: `busy` is high from the edge that accepts a start with a non-zero divisor until the edge that raises `done`, and it is low while `done` is high.
- R5: `done` is high for exactly one cycle per operation, and `quotient`, `remainder` and `div_zero` keep their values until the next operation completes.
- R6: A start with divisor 0 raises `done` on the very edge that samples `start`, with `div_zero` = 1, `quotient` all ones, `remainder` equal to the dividend, and `busy` staying low.
- R7: `div_zero` returns to 0 as soon as a start with a non-zero divisor is accepted, and it is 0 when that operation's `done` pulses.
- R8: A `start` pulse that arrives while `busy` is high is ignored: the running operation finishes with its original operands and original latency.
- R9: Whenever `done` pulses for a non-zero divisor, `remainder` is strictly less than the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; sampled only while idle |
| dividend | input | W | Unsigned dividend, sampled with start |
| divisor | input | W | Unsigned divisor, sampled with start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | W | Quotient of the last completed division |
| remainder | output | W | Remainder of the last completed division |
| div_zero | output | 1 | Last completed start had a zero divisor |

## Verification
The bench targets operands whose last quotient bit is 0. There the final residual is negative, and a design that skipped or misapplied the correction would return a remainder off by the divisor or finish a cycle early. It also drives a divisor larger than the dividend, a divisor of 1 with a full-scale dividend, and equal operands. A wrong add/subtract choice or a narrow residual register would break the quotient bits on these. A start injected mid-operation would corrupt the result or restart the count if it were not ignored. The zero-divisor case followed by a normal division checks that the flag and the all-ones quotient do not leak into the next result.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
    typedef enum logic [1:0] {
        NRD_IDLE = 2'd0,
        NRD_RUN  = 2'd1,
        NRD_FIX  = 2'd2
    } nrd_state_e;
endpackage

// File: rtl/nrdiv_step.sv
// One non-restoring iteration: joint left shift, then add or subtract.
module nrdiv_step #(
    parameter int W = 8
) (
    input  logic [W:0]   p_in,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W:0]   p_out,
    output logic [W-1:0] a_out
);
    logic [W:0] shifted;
    logic [W:0] b_ext;

    always_comb begin
        shifted = {p_in[W-1:0], a_in[W-1]};
        b_ext   = {1'b0, b_in};
        // sign of the residual before the step picks the operation
        if (p_in[W]) p_out = shifted + b_ext;
        else         p_out = shifted - b_ext;
        a_out = {a_in[W-2:0], ~p_out[W]};
    end
endmodule

// File: rtl/nrdiv_fix.sv
// Remainder from the final residual: add the divisor back once if negative.
module nrdiv_fix #(
    parameter int W = 8
) (
    input  logic [W:0]   p_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] rem_out
);
    logic [W:0] sum;

    always_comb begin
        sum     = p_in + {1'b0, b_in};
        rem_out = p_in[W] ? sum[W-1:0] : p_in[W-1:0];
    end
endmodule

// File: rtl/nrdiv_seq.sv
module nrdiv_seq
    import nrdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       zero_div,
    input  logic       step_neg,
    output nrd_state_e state_o,
    output logic       last_o,
    output logic       done_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        nrd_state_e    st;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            NRD_IDLE: begin
                if (start) begin
                    if (zero_div) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st  = NRD_RUN;
                        seq_d.cnt = CW'(W);
                    end
                end
            end
            NRD_RUN: begin
                seq_d.cnt = seq_q.cnt - 1'b1;
                if (seq_q.cnt == CW'(1)) begin
                    if (step_neg) begin
                        seq_d.st = NRD_FIX;
                    end else begin
                        seq_d.st   = NRD_IDLE;
                        seq_d.done = 1'b1;
                    end
                end
            end
            NRD_FIX: begin
                seq_d.st   = NRD_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = NRD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= NRD_IDLE;
            seq_q.cnt  <= '0;
            seq_q.done <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.st;
    assign last_o  = (seq_q.cnt == CW'(1));
    assign done_o  = seq_q.done;

    // R3: the correction cycle always ends the operation
    p_fix_then_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == NRD_FIX) |=> seq_q.done);

    // R4: completion is only ever reported from idle
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> (seq_q.st == NRD_IDLE));

    // R3: the counter is never zero while iterating
    p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == NRD_RUN) |-> (seq_q.cnt != '0));
endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top
    import nrdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_zero
);
    localparam int PW = W + 1;

    typedef struct packed {
        logic [PW-1:0] p;
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [W-1:0]  quo;
        logic [W-1:0]  rem;
        logic          dz;
    } dp_t;

    dp_t dp_d, dp_q;

    nrd_state_e   st;
    logic         last;
    logic         zero_div;
    logic [PW-1:0] step_p;
    logic [W-1:0] step_a;
    logic [W-1:0] fix_rem;

    assign zero_div = (divisor == '0);

    nrdiv_step #(.W(W)) u_step (
        .p_in (dp_q.p),
        .a_in (dp_q.a),
        .b_in (dp_q.b),
        .p_out(step_p),
        .a_out(step_a)
    );

    nrdiv_fix #(.W(W)) u_fix (
        .p_in   (dp_q.p),
        .b_in   (dp_q.b),
        .rem_out(fix_rem)
    );

    nrdiv_seq #(.W(W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .zero_div(zero_div),
        .step_neg(step_p[W]),
        .state_o (st),
        .last_o  (last),
        .done_o  (done)
    );

    always_comb begin
        dp_d = dp_q;
        case (st)
            NRD_IDLE: begin
                if (start) begin
                    if (zero_div) begin
                        dp_d.quo = '1;
                        dp_d.rem = dividend;
                        dp_d.dz  = 1'b1;
                    end else begin
                        dp_d.p  = '0;
                        dp_d.a  = dividend;
                        dp_d.b  = divisor;
                        dp_d.dz = 1'b0;
                    end
                end
            end
            NRD_RUN: begin
                dp_d.p = step_p;
                dp_d.a = step_a;
                if (last && !step_p[W]) begin
                    dp_d.quo = step_a;
                    dp_d.rem = step_p[W-1:0];
                end
            end
            NRD_FIX: begin
                dp_d.quo = dp_q.a;
                dp_d.rem = fix_rem;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign busy      = (st != NRD_IDLE);
    assign quotient  = dp_q.quo;
    assign remainder = dp_q.rem;
    assign div_zero  = dp_q.dz;

    // R2: non-restoring invariant, -B <= P < B while iterating
    p_residual_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == NRD_RUN) |-> (($signed(dp_q.p) < $signed({1'b0, dp_q.b})) &&
                             ($signed(dp_q.p) >= -$signed({1'b0, dp_q.b}))));

    // R3: the correction cycle is entered only with a negative residual
    p_fix_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == NRD_FIX) |-> dp_q.p[W]);

    // R9: remainder below the divisor on completion
    p_rem_lt_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (remainder < dp_q.b));

    // R6: zero-divisor completion returns an all-ones quotient
    p_zero_quo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == '1));

    // R8: a start while busy leaves the held divisor alone
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dp_q.b));
endmodule

// File: tb/sim_nrdiv_top.sv
module sim_nrdiv_top;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // {dividend, divisor, quotient, remainder}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd27,  8'd5,   8'd5,   8'd2},
        {8'd255, 8'd1,   8'd255, 8'd0},
        {8'd255, 8'd255, 8'd1,   8'd0},
        {8'd0,   8'd7,   8'd0,   8'd0},
        {8'd100, 8'd7,   8'd14,  8'd2},
        {8'd7,   8'd100, 8'd0,   8'd7},
        {8'd128, 8'd3,   8'd42,  8'd2},
        {8'd200, 8'd16,  8'd12,  8'd8},
        {8'd1,   8'd2,   8'd0,   8'd1},
        {8'd254, 8'd127, 8'd2,   8'd0},
        {8'd13,  8'd13,  8'd1,   8'd0},
        {8'd250, 8'd251, 8'd0,   8'd250}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero;
    logic [W-1:0] quotient, remainder;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nrdiv_top #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // returns edges counted after the start edge, and busy after that edge
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                           output int lat, output logic busy1, output logic busy_at_done);
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        busy1 = busy;
        lat = 0;
        while (!done && lat < 40) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        busy_at_done = busy;
    endtask

    task automatic full_check(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                              input logic [W-1:0] eq, input logic [W-1:0] er);
        int lat;
        logic b1, bd;
        run_div(a, b, lat, b1, bd);
        chk({tag, " R2 quotient"}, int'(quotient), int'(eq));
        chk({tag, " R2 remainder"}, int'(remainder), int'(er));
        chk({tag, " R2 recombine"}, int'(quotient) * int'(b) + int'(remainder), int'(a));
        chk({tag, " R9 rem<div"}, int'(remainder < b), 1);
        chk({tag, " R3 latency"}, lat, eq[0] ? W : W + 1);
        chk({tag, " R4 busy after start"}, int'(b1), 1);
        chk({tag, " R4 busy low at done"}, int'(bd), 0);
        chk({tag, " R7 flag clear"}, int'(div_zero), 0);
        @(negedge clk);
        chk({tag, " R5 done one cycle"}, int'(done), 0);
        chk({tag, " R5 quotient held"}, int'(quotient), int'(eq));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;
        logic b1, bd;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 div_zero", int'(div_zero), 0);
        chk("R1 quotient", int'(quotient), 0);
        chk("R1 remainder", int'(remainder), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            full_check("vec", VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
        end

        // R6 zero divisor
        run_div(8'd77, 8'd0, lat, b1, bd);
        chk("R6 latency", lat, 0);
        chk("R6 busy stays low", int'(b1), 0);
        chk("R6 flag", int'(div_zero), 1);
        chk("R6 quotient", int'(quotient), 255);
        chk("R6 remainder", int'(remainder), 77);
        repeat (3) @(negedge clk);
        chk("R5 flag held", int'(div_zero), 1);
        chk("R5 remainder held", int'(remainder), 77);

        // R7 next nonzero division clears the flag at acceptance
        @(negedge clk);
        dividend = 8'd9; divisor = 8'd4; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R7 flag cleared on accept", int'(div_zero), 0);
        while (!done) @(negedge clk);
        chk("R7 quotient after zero", int'(quotient), 2);
        chk("R7 remainder after zero", int'(remainder), 1);

        // R8 start while busy is ignored
        @(negedge clk);
        dividend = 8'd27; divisor = 8'd5; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        dividend = 8'd200; divisor = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 latency unchanged", lat, W);
        chk("R8 quotient", int'(quotient), 5);
        chk("R8 remainder", int'(remainder), 2);
        chk("R8 no flag", int'(div_zero), 0);

        // random operands, expected from integer arithmetic
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            if (rb == '0) rb = 8'd1;
            full_check("rand", ra, rb, ra / rb, ra % rb);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule